// File: doc/BRIEF.md
# Interrupt controller error status reporter

This block gathers error conditions raised inside a local interrupt controller and reports them to software. Error bits arrive as masks, either on a strobe from the vector-table dispatcher or from a check made here on command-register writes. They are ORed into a hidden pending word. Software sees them only after it writes the status register, which moves the pending word into the visible status register and clears the pending word in the same edge.

Every cycle that brings a new error leads to one attempt to deliver the error interrupt in the following cycle. The attempt reads the error vector-table entry, always treats it as fixed delivery, and raises a request with the entry's vector toward the pending-vector logic. An attempt that itself fails because the vector is illegal records one more error bit, but it never starts another attempt. This keeps the error interrupt from feeding on itself.

The control is a two-state machine. `ST_IDLE` means no attempt is due. `ST_FIRE` means an attempt is made in this cycle. The transition *raise* (`ST_IDLE` to `ST_FIRE`) happens on a cycle with a new error. The transition *repeat* (`ST_FIRE` to `ST_FIRE`) happens when another new error arrives during an attempt. The transition *settle* (`ST_FIRE` to `ST_IDLE`) happens when no new error arrives.

Top module: `irq_err_reporter`

## Requirements
- R1: Error mask bits from an accepted dispatcher strobe (`lvt_err_vld` high, `lvt_err_mask` non-zero) are ORed into the pending word on that edge. They do not appear on `status_rdata` until a later status write.
- R2: A write to address 0x280 loads the visible status register with the pending word and clears the pending word on the same edge. `status_rdata` shows the new value from the next cycle on.
- R3: In the cycle after any cycle with a new error, one delivery attempt is made. If entry bit 16 is 0 and entry bits 7:0 are 16 or more, `irq_req` is high for that cycle and `irq_vector` equals entry bits 7:0. Entry bits 10:8 (delivery mode) are ignored, so delivery is always fixed.
- R4: An attempt whose entry vector is below 16 raises no request. It ORs send-illegal-vector (status bit 5) into the pending word, and it causes no further attempt.
- R5: A write to address 0x300 with data bits 10:8 equal to 000 (fixed) and data bits 7:0 below 16 ORs status bit 5 into the pending word and counts as a new error, and `cmd_send` stays low. Any other write to 0x300 pulses `cmd_send` high in the next cycle.
- R6: An attempt with entry bit 16 set (masked) raises no request and records no further error. The triggering error stays recorded.
- R7: After reset, the pending word and the status register are zero, and neither `irq_req` nor `cmd_send` is asserted.
- R8: When an error arrives in the same cycle as a status write, the error lands in the freshly cleared pending word. It shows up at the following status write.
- R9: Status bit positions: bit 5 is send-illegal-vector, bit 6 is receive-illegal-vector, bit 7 is illegal-register-address. Dispatcher masks are stored bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write offset |
| wr_data | input | 32 | Register write data |
| lvt_err_vld | input | 1 | Error strobe from the vector-table dispatcher |
| lvt_err_mask | input | 8 | Error bits carried by the strobe |
| err_entry | input | 32 | Error vector-table entry: vector 7:0, mode 10:8, mask 16 |
| status_rdata | output | 8 | Visible status register |
| irq_req | output | 1 | Fixed-mode error interrupt request |
| irq_vector | output | 8 | Vector of the request |
| cmd_send | output | 1 | Legal command write forwarded to the sending logic |

## Verification
A status write or an error strobe changes `status_rdata` and the pending word at the next edge. The bench compares `status_rdata` one cycle after each write. The delivery attempt is due exactly one cycle after the error, and `irq_req`/`irq_vector` are combinational from the state and the current entry. The bench therefore checks them in the cycle after the stimulus, with the entry it drives in that cycle. `cmd_send` is registered and is compared one cycle after the command write. A reference model in the bench advances once per edge, so that every output is checked against the cycle in which it is due, under both directed and seeded random stimulus.

// File: rtl/irq_err_pkg.sv
package irq_err_pkg;
    localparam int ESR_W        = 8;
    localparam int VEC_W        = 8;
    localparam int ADDR_W       = 12;
    localparam int DATA_W       = 32;
    localparam int MIN_VEC      = 16;
    localparam int BIT_SEND_ILL = 5;
    localparam int BIT_RECV_ILL = 6;
    localparam int BIT_BAD_ADDR = 7;
    localparam int ENT_MASK_BIT = 16;
    localparam int MODE_LO      = 8;
    localparam int MODE_W       = 3;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h280;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 12'h300;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FIRE = 1'b1
    } fire_state_t;
endpackage

// File: rtl/esr_cmd_check.sv
module esr_cmd_check
    import irq_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [10:0]       cmd_bits,
    output logic [ESR_W-1:0]  cmd_err_mask,
    output logic              cmd_send
);
    logic is_cmd;
    logic bad_vec;

    assign is_cmd  = wr_en && (wr_addr == OFS_CMD);
    assign bad_vec = (cmd_bits[MODE_LO +: MODE_W] == '0) &&
                     (cmd_bits[VEC_W-1:0] < VEC_W'(MIN_VEC));

    always_comb begin
        cmd_err_mask = '0;
        if (is_cmd && bad_vec)
            cmd_err_mask[BIT_SEND_ILL] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_send <= 1'b0;
        else        cmd_send <= is_cmd && !bad_vec;
    end

    AST_CMD_SEND_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_send |-> $past(wr_en && wr_addr == OFS_CMD)); // R5
endmodule

// File: rtl/esr_accum.sv
module esr_accum
    import irq_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ESR_W-1:0] in_mask,
    input  logic             status_wr,
    output logic [ESR_W-1:0] status_q
);
    logic [ESR_W-1:0] pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
            status_q  <= '0;
        end else begin
            if (status_wr) begin
                status_q  <= pending_q;
                pending_q <= in_mask;
            end else begin
                pending_q <= pending_q | in_mask;
            end
        end
    end

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !status_wr |=> $stable(status_q)); // R1
    AST_PENDING_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending_q & $past(in_mask)) == $past(in_mask))); // R8
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr && in_mask == '0) |=> (pending_q == '0)); // R2
endmodule

// File: rtl/esr_fire_fsm.sv
module esr_fire_fsm
    import irq_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             new_err,
    input  logic [VEC_W-1:0] ent_vector,
    input  logic             ent_masked,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector,
    output logic [ESR_W-1:0] self_err_mask
);
    fire_state_t state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = new_err ? ST_FIRE : ST_IDLE;
            ST_FIRE: state_d = new_err ? ST_FIRE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_req       = 1'b0;
        irq_vector    = '0;
        self_err_mask = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FIRE: begin
                if (!ent_masked) begin
                    if (ent_vector < VEC_W'(MIN_VEC)) begin
                        self_err_mask[BIT_SEND_ILL] = 1'b1;
                    end else begin
                        irq_req    = 1'b1;
                        irq_vector = ent_vector;
                    end
                end
            end
            default: ;
        endcase
    end

    AST_REQ_NEEDS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(new_err)); // R3
    AST_SELF_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (self_err_mask != '0 && !new_err) |=> (state_q == ST_IDLE)); // R4
endmodule

// File: rtl/irq_err_reporter.sv
module irq_err_reporter
    import irq_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lvt_err_vld,
    input  logic [ESR_W-1:0]  lvt_err_mask,
    input  logic [DATA_W-1:0] err_entry,
    output logic [ESR_W-1:0]  status_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector,
    output logic              cmd_send
);
    logic [ESR_W-1:0] cmd_err_mask;
    logic [ESR_W-1:0] self_err_mask;
    logic [ESR_W-1:0] ext_mask;
    logic [ESR_W-1:0] all_mask;
    logic             new_err;
    logic             status_wr;
    logic             unused_bits;

    assign unused_bits = ^{wr_data[DATA_W-1:11], err_entry[DATA_W-1:ENT_MASK_BIT+1],
                           err_entry[ENT_MASK_BIT-1:VEC_W]};

    assign status_wr = wr_en && (wr_addr == OFS_STATUS);
    assign ext_mask  = (lvt_err_vld ? lvt_err_mask : '0) | cmd_err_mask;
    assign new_err   = (ext_mask != '0);
    assign all_mask  = ext_mask | self_err_mask;

    esr_cmd_check u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .cmd_bits     (wr_data[10:0]),
        .cmd_err_mask (cmd_err_mask),
        .cmd_send     (cmd_send)
    );

    esr_fire_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .new_err       (new_err),
        .ent_vector    (err_entry[VEC_W-1:0]),
        .ent_masked    (err_entry[ENT_MASK_BIT]),
        .irq_req       (irq_req),
        .irq_vector    (irq_vector),
        .self_err_mask (self_err_mask)
    );

    esr_accum u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_mask   (all_mask),
        .status_wr (status_wr),
        .status_q  (status_rdata)
    );

    AST_REQ_LEGAL_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector >= VEC_W'(MIN_VEC))); // R4
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_entry[ENT_MASK_BIT] |-> !irq_req); // R6
endmodule

// File: tb/test_irq_err_reporter.sv
module test_irq_err_reporter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        lvt_err_vld = 1'b0;
    logic [7:0]  lvt_err_mask = '0;
    logic [31:0] err_entry = '0;
    logic [7:0]  status_rdata;
    logic        irq_req;
    logic [7:0]  irq_vector;
    logic        cmd_send;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    bit       m_fire = 0;
    bit [7:0] m_pend = 0;
    bit [7:0] m_stat = 0;
    bit       m_cmd = 0;

    irq_err_reporter i_irq_err_reporter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lvt_err_vld(lvt_err_vld), .lvt_err_mask(lvt_err_mask), .err_entry(err_entry),
        .status_rdata(status_rdata), .irq_req(irq_req), .irq_vector(irq_vector),
        .cmd_send(cmd_send)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    function automatic bit exp_req(bit fire, logic [31:0] ent);
        return fire && !ent[16] && (ent[7:0] >= 8'd16);
    endfunction

    function automatic bit [7:0] exp_self(bit fire, logic [31:0] ent);
        return (fire && !ent[16] && ent[7:0] < 8'd16) ? 8'h20 : 8'h00;
    endfunction

    // Drive one cycle: inputs applied at negedge, combinational outputs checked,
    // model advanced for the edge, registered outputs checked at next negedge.
    task automatic step(bit we, logic [11:0] a, logic [31:0] d, bit v, logic [7:0] m,
                        logic [31:0] ent, string tag);
        bit sw, iscmd, cbad;
        bit [7:0] inm;
        wr_en = we; wr_addr = a; wr_data = d;
        lvt_err_vld = v; lvt_err_mask = m; err_entry = ent;
        #1;
        check({tag, " R3 irq_req"}, irq_req, exp_req(m_fire, ent));
        if (exp_req(m_fire, ent))
            check({tag, " R3 irq_vector"}, irq_vector, ent[7:0]);
        sw    = we && a == 12'h280;
        iscmd = we && a == 12'h300;
        cbad  = iscmd && d[10:8] == 3'b000 && d[7:0] < 8'd16;
        inm   = (v ? m : 8'h00) | (cbad ? 8'h20 : 8'h00);
        if (sw) m_stat = m_pend;
        m_pend = (sw ? 8'h00 : m_pend) | inm | exp_self(m_fire, ent);
        m_fire = (inm != 0);
        m_cmd  = iscmd && !cbad;
        @(negedge clk);
        check({tag, " R1 status_rdata"}, status_rdata, m_stat);
        check({tag, " R5 cmd_send"}, cmd_send, m_cmd);
    endtask

    task automatic idle(string tag, logic [31:0] ent);
        step(0, 12'h000, 0, 0, 0, ent, tag);
    endtask

    task automatic read_status(string tag);
        step(1, 12'h280, 0, 0, 0, 32'h0001_0000, tag);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                bad++; total++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R7 reset state
        check("R7 status after reset", status_rdata, 0);
        check("R7 irq_req after reset", irq_req, 0);
        check("R7 cmd_send after reset", cmd_send, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 hidden accumulation, R2 copy on write, R9 bit storage
        step(0, 0, 0, 1, 8'h40, 32'h0001_0000, "R1 strobe a");
        step(0, 0, 0, 1, 8'h80, 32'h0001_0000, "R1 strobe b");
        check("R1 still hidden", status_rdata, 8'h00);
        read_status("R2 status write");
        check("R2 R9 status shows OR", status_rdata, 8'hC0);
        read_status("R2 second write");
        check("R2 pending was cleared", status_rdata, 8'h00);

        // R3 fire with legal vector; mode bits (NMI=100) ignored
        step(0, 0, 0, 1, 8'h40, 32'h0000_0433, "R3 trigger");
        idle("R3 attempt", 32'h0000_0433);
        idle("R3 single attempt", 32'h0000_0433);

        // R4 illegal entry vector: bit5 recorded, no refire
        read_status("R4 clear");
        step(0, 0, 0, 1, 8'h80, 32'h0000_0005, "R4 trigger");
        idle("R4 attempt", 32'h0000_0005);
        idle("R4 no refire", 32'h0000_0005);
        read_status("R4 read");
        check("R4 status has send-illegal", status_rdata, 8'hA0);

        // R6 masked entry
        step(0, 0, 0, 1, 8'h40, 32'h0001_0003, "R6 trigger");
        idle("R6 masked attempt", 32'h0001_0003);
        read_status("R6 read");
        check("R6 only triggering bit", status_rdata, 8'h40);

        // R5 command writes
        step(1, 12'h300, 32'h0000_000A, 0, 0, 32'h0000_0050, "R5 bad fixed cmd");
        idle("R5 error attempt", 32'h0000_0050);
        step(1, 12'h300, 32'h0000_0405, 0, 0, 32'h0000_0050, "R5 nmi low vec ok");
        step(1, 12'h300, 32'h0000_0020, 0, 0, 32'h0000_0050, "R5 fixed legal");
        read_status("R5 read");
        check("R5 send-illegal recorded", status_rdata, 8'h20);

        // R8 strobe coincident with status write
        step(1, 12'h280, 0, 1, 8'h80, 32'h0001_0000, "R8 coincident");
        read_status("R8 read");
        check("R8 bit survives clear", status_rdata, 8'h80);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ent;
            logic [31:0] d;
            int sel;
            ent = {15'h0, 1'($urandom_range(0, 3) == 0), 5'h0, 3'($urandom), 8'($urandom_range(0, 40))};
            d   = {21'h0, 3'($urandom_range(0, 1) == 0 ? 0 : $urandom), 8'($urandom_range(0, 30))};
            sel = $urandom_range(0, 9);
            step(sel < 3, sel == 0 ? 12'h280 : (sel < 3 ? 12'h300 : 12'h2F0), d,
                 $urandom_range(0, 2) == 0, 8'($urandom) & 8'hE0, ent, "RND R1 R3");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule